// File: doc/BRIEF.md
# Multi-Lane Serial Write Command Receiver

This block sits behind the pins of a serial flash slave and turns the command phase of a write-type command into parallel words. While chip select is low it samples one, two or four data lines on each rising edge of the serial clock. It first collects an 8-bit opcode on line 0 alone and decodes it. Then it collects a 3-byte address and a stream of data bytes, each phase using the lane count that the opcode selects. The address phase and the data phase may use different lane counts within one command.

The block runs entirely on the serial clock, and the clock must keep toggling for at least two cycles after chip select rises so the end of frame can be reported. Opcode, address and data are given as registered words, each marked by a one-cycle strobe. When chip select rises, an end-of-frame pulse comes out together with a flag. The flag tells whether the frame ended on a whole data byte after at least one data byte. An unrecognised opcode is still reported, but the rest of that frame is dropped. Executing the command, driving the bus and dummy cycles are left to other blocks.

The controller has five states. ST_IDLE waits for chip select. ST_OPC collects the opcode. ST_ADDR collects the address. ST_DATA collects data bytes. ST_SKIP discards the rest of a frame whose opcode was not recognised. The transitions are as follows. ST_IDLE goes to ST_OPC on the first edge with chip select low, and that edge already samples the first opcode bit. ST_OPC goes to ST_ADDR on a recognised opcode and to ST_SKIP on any other. ST_ADDR goes to ST_DATA after the last address byte. Every state other than ST_IDLE returns to ST_IDLE on any edge that samples chip select high.

Top module: `mlr_cmd_rx`

## Requirements
- R1: After reset, opcode_valid, addr_valid, data_valid, frame_end and frame_ok are 0, and opcode, addr and data_byte are 0.
- R2: The opcode is taken MSB first from dq[0] on the first 8 rising edges with cs_n low. opcode_valid pulses for one cycle right after the 8th of these edges, and opcode holds the value.
- R3: The lane counts for (address, data) are as follows. OPC_PAGE gives (1,1), OPC_DUAL_DATA (1,2), OPC_DUAL_ALL (2,2), OPC_QUAD_DATA (1,4) and OPC_QUAD_ALL (4,4). The defaults are 8'h02, 8'hA2, 8'hD2, 8'h32 and 8'h12.
- R4: In 2- and 4-lane phases, each edge shifts in a group MSB first. The higher-numbered line carries the more significant bit: dq[1:0] gives 2 bits and dq[3:0] gives 4 bits. With 1 lane, only dq[0] is used.
- R5: The address is 3 bytes, MSB first. addr_valid pulses for one cycle after the last address edge, which is 24, 12 or 6 edges after the opcode for 1, 2 or 4 lanes. addr then holds the whole address.
- R6: Each data byte takes 8, 4 or 2 edges and gives a one-cycle data_valid pulse with the byte on data_byte. There is no limit on the number of data bytes.
- R7: For an opcode that R3 does not list, opcode_valid still pulses with its value. No addr_valid or data_valid follows until cs_n has risen, and the next frame is decoded normally.
- R8: frame_end pulses for exactly one cycle, right after the first rising edge that samples cs_n high following a frame.
- R9: frame_ok equals frame_end when the frame ended in the data phase with at least one data byte and no leftover bits. In every other case frame_ok is 0: address cut short, no data bytes, partial byte, or unknown opcode.
- R10: An edge that samples cs_n high discards any partial bits. No strobe follows such an edge, and the next frame starts again from the opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; all bits are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| dq | input | 4 | Data lines; dq[0] is the single-lane line |
| opcode | output | 8 | Last opcode received |
| opcode_valid | output | 1 | One-cycle strobe: opcode updated |
| addr | output | 24 | Address, complete when addr_valid pulses |
| addr_valid | output | 1 | One-cycle strobe: address complete |
| data_byte | output | 8 | Last data byte received |
| data_valid | output | 1 | One-cycle strobe: data_byte updated |
| frame_end | output | 1 | One-cycle strobe after cs_n rises |
| frame_ok | output | 1 | Valid with frame_end: byte-aligned and non-empty data phase |

## Verification
Take t0 as the falling edge on which chip select is driven low, with one bus unit driven per cycle after that. Then opcode_valid is due 8 cycles after t0 and addr_valid 8 plus 24, 12 or 6 cycles after t0. Data byte k is due a further (k+1)·8/lanes cycles later. frame_end is due one cycle after the last driven unit. The bench counts rising edges, logs the cycle of each strobe at the falling edge that follows, and compares the logged cycles with these sums. It also compares the values and the number of strobes in each frame with figures that bench functions compute from the opcode.

// File: rtl/mlr_pkg.sv
`timescale 1ns/1ps
package mlr_pkg;

    typedef enum logic [1:0] {
        LANE_X1 = 2'd0,
        LANE_X2 = 2'd1,
        LANE_X4 = 2'd2
    } lane_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_OPC  = 3'd1,
        ST_ADDR = 3'd2,
        ST_DATA = 3'd3,
        ST_SKIP = 3'd4
    } rx_state_e;

    typedef struct packed {
        logic  known;
        lane_e addr_lanes;
        lane_e data_lanes;
    } cmd_cfg_t;

endpackage

// File: rtl/mlr_decode.sv
`timescale 1ns/1ps
module mlr_decode
    import mlr_pkg::*;
#(
    parameter logic [7:0] OPC_PAGE      = 8'h02,
    parameter logic [7:0] OPC_DUAL_DATA = 8'hA2,
    parameter logic [7:0] OPC_DUAL_ALL  = 8'hD2,
    parameter logic [7:0] OPC_QUAD_DATA = 8'h32,
    parameter logic [7:0] OPC_QUAD_ALL  = 8'h12
) (
    input  logic [7:0] opc,
    output cmd_cfg_t   cfg
);

    // Priority chain: parameters could in principle collide, first match wins.
    always_comb begin
        cfg = '{known: 1'b0, addr_lanes: LANE_X1, data_lanes: LANE_X1};
        if (opc == OPC_PAGE) begin
            cfg = '{known: 1'b1, addr_lanes: LANE_X1, data_lanes: LANE_X1};
        end else if (opc == OPC_DUAL_DATA) begin
            cfg = '{known: 1'b1, addr_lanes: LANE_X1, data_lanes: LANE_X2};
        end else if (opc == OPC_DUAL_ALL) begin
            cfg = '{known: 1'b1, addr_lanes: LANE_X2, data_lanes: LANE_X2};
        end else if (opc == OPC_QUAD_DATA) begin
            cfg = '{known: 1'b1, addr_lanes: LANE_X1, data_lanes: LANE_X4};
        end else if (opc == OPC_QUAD_ALL) begin
            cfg = '{known: 1'b1, addr_lanes: LANE_X4, data_lanes: LANE_X4};
        end
    end

endmodule

// File: rtl/mlr_shift.sv
`timescale 1ns/1ps
module mlr_shift
    import mlr_pkg::*;
#(
    parameter  int BYTE_W = 8,
    localparam int CNT_W  = $clog2(BYTE_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              shift_en,
    input  lane_e             lanes,
    input  logic [3:0]        dq,
    output logic [BYTE_W-1:0] byte_next,
    output logic              byte_done,
    output logic              partial
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    logic [BYTE_W-1:0] sreg;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  step;
    logic [CNT_W-1:0]  cnt_next;

    // Group of bits taken this edge, higher line = more significant bit.
    always_comb begin
        unique case (lanes)
            LANE_X2: begin
                byte_next = {sreg[BYTE_W-3:0], dq[1:0]};
                step      = CNT_W'(2);
            end
            LANE_X4: begin
                byte_next = {sreg[BYTE_W-5:0], dq[3:0]};
                step      = CNT_W'(4);
            end
            default: begin
                byte_next = {sreg[BYTE_W-2:0], dq[0]};
                step      = CNT_W'(1);
            end
        endcase
        cnt_next  = cnt + step;
        byte_done = shift_en && (cnt_next == FULL);
        partial   = (cnt != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg <= '0;
            cnt  <= '0;
        end else if (clear) begin
            sreg <= '0;
            cnt  <= '0;
        end else if (shift_en) begin
            sreg <= byte_next;
            cnt  <= byte_done ? '0 : cnt_next;
        end
    end

endmodule

// File: rtl/mlr_ctrl.sv
`timescale 1ns/1ps
module mlr_ctrl
    import mlr_pkg::*;
#(
    parameter  int ADDR_BYTES = 3,
    parameter  int BYTE_W     = 8,
    localparam int ADDR_W     = ADDR_BYTES * BYTE_W,
    localparam int AC_W       = $clog2(ADDR_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] byte_next,
    input  logic              partial,
    input  cmd_cfg_t          cfg_in,
    output logic              shift_en,
    output logic              clear,
    output lane_e             lanes,
    output logic [BYTE_W-1:0] opcode,
    output logic              opcode_valid,
    output logic [ADDR_W-1:0] addr,
    output logic              addr_valid,
    output logic [BYTE_W-1:0] data_byte,
    output logic              data_valid,
    output logic              frame_end,
    output logic              frame_ok
);

    localparam logic [AC_W-1:0] ADDR_LAST = AC_W'(ADDR_BYTES - 1);

    rx_state_e        state;
    rx_state_e        state_nx;
    lane_e            addr_lanes_q;
    lane_e            data_lanes_q;
    logic [AC_W-1:0]  addr_cnt;
    logic             got_data;

    // Datapath steering from the current state.
    always_comb begin
        clear    = cs_n;
        shift_en = !cs_n && (state != ST_SKIP);
        unique case (state)
            ST_ADDR: lanes = addr_lanes_q;
            ST_DATA: lanes = data_lanes_q;
            default: lanes = LANE_X1;
        endcase
    end

    // Next-state logic.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (!cs_n) state_nx = ST_OPC;
            ST_OPC: begin
                if (cs_n)           state_nx = ST_IDLE;
                else if (byte_done) state_nx = cfg_in.known ? ST_ADDR : ST_SKIP;
            end
            ST_ADDR: begin
                if (cs_n)                                   state_nx = ST_IDLE;
                else if (byte_done && addr_cnt == ADDR_LAST) state_nx = ST_DATA;
            end
            ST_DATA: if (cs_n) state_nx = ST_IDLE;
            ST_SKIP: if (cs_n) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Registered outputs and frame bookkeeping.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opcode       <= '0;
            opcode_valid <= 1'b0;
            addr         <= '0;
            addr_valid   <= 1'b0;
            data_byte    <= '0;
            data_valid   <= 1'b0;
            frame_end    <= 1'b0;
            frame_ok     <= 1'b0;
            addr_lanes_q <= LANE_X1;
            data_lanes_q <= LANE_X1;
            addr_cnt     <= '0;
            got_data     <= 1'b0;
        end else begin
            opcode_valid <= 1'b0;
            addr_valid   <= 1'b0;
            data_valid   <= 1'b0;
            frame_end    <= 1'b0;
            frame_ok     <= 1'b0;
            if (cs_n) begin
                if (state != ST_IDLE) begin
                    frame_end <= 1'b1;
                    frame_ok  <= (state == ST_DATA) && !partial && got_data;
                end
                addr_cnt <= '0;
                got_data <= 1'b0;
            end else if (byte_done) begin
                unique case (state)
                    ST_OPC: begin
                        opcode       <= byte_next;
                        opcode_valid <= 1'b1;
                        addr_lanes_q <= cfg_in.addr_lanes;
                        data_lanes_q <= cfg_in.data_lanes;
                    end
                    ST_ADDR: begin
                        addr     <= {addr[ADDR_W-BYTE_W-1:0], byte_next};
                        addr_cnt <= addr_cnt + AC_W'(1);
                        if (addr_cnt == ADDR_LAST) addr_valid <= 1'b1;
                    end
                    ST_DATA: begin
                        data_byte  <= byte_next;
                        data_valid <= 1'b1;
                        got_data   <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/mlr_cmd_rx.sv
`timescale 1ns/1ps
module mlr_cmd_rx
    import mlr_pkg::*;
#(
    parameter logic [7:0] OPC_PAGE      = 8'h02,
    parameter logic [7:0] OPC_DUAL_DATA = 8'hA2,
    parameter logic [7:0] OPC_DUAL_ALL  = 8'hD2,
    parameter logic [7:0] OPC_QUAD_DATA = 8'h32,
    parameter logic [7:0] OPC_QUAD_ALL  = 8'h12,
    parameter int         ADDR_BYTES    = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cs_n,
    input  logic [3:0]              dq,
    output logic [7:0]              opcode,
    output logic                    opcode_valid,
    output logic [ADDR_BYTES*8-1:0] addr,
    output logic                    addr_valid,
    output logic [7:0]              data_byte,
    output logic                    data_valid,
    output logic                    frame_end,
    output logic                    frame_ok
);

    localparam int BYTE_W = 8;

    cmd_cfg_t          cfg;
    lane_e             lanes;
    logic              shift_en;
    logic              clear;
    logic [BYTE_W-1:0] byte_next;
    logic              byte_done;
    logic              partial;

    mlr_shift #(.BYTE_W(BYTE_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .shift_en  (shift_en),
        .lanes     (lanes),
        .dq        (dq),
        .byte_next (byte_next),
        .byte_done (byte_done),
        .partial   (partial)
    );

    mlr_decode #(
        .OPC_PAGE      (OPC_PAGE),
        .OPC_DUAL_DATA (OPC_DUAL_DATA),
        .OPC_DUAL_ALL  (OPC_DUAL_ALL),
        .OPC_QUAD_DATA (OPC_QUAD_DATA),
        .OPC_QUAD_ALL  (OPC_QUAD_ALL)
    ) u_decode (
        .opc (byte_next),
        .cfg (cfg)
    );

    mlr_ctrl #(.ADDR_BYTES(ADDR_BYTES), .BYTE_W(BYTE_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_n         (cs_n),
        .byte_done    (byte_done),
        .byte_next    (byte_next),
        .partial      (partial),
        .cfg_in       (cfg),
        .shift_en     (shift_en),
        .clear        (clear),
        .lanes        (lanes),
        .opcode       (opcode),
        .opcode_valid (opcode_valid),
        .addr         (addr),
        .addr_valid   (addr_valid),
        .data_byte    (data_byte),
        .data_valid   (data_valid),
        .frame_end    (frame_end),
        .frame_ok     (frame_ok)
    );

endmodule

// File: rtl/mlr_checker.sv
`timescale 1ns/1ps
module mlr_checker (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic opcode_valid,
    input logic addr_valid,
    input logic data_valid,
    input logic frame_end,
    input logic frame_ok
);

    // R10: an edge seeing chip select high yields no strobe.
    p_no_strobe_cs_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !(opcode_valid || addr_valid || data_valid));

    // R8: end of frame only after chip select was seen high.
    p_end_after_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> $past(cs_n));

    // R8: end of frame lasts a single cycle.
    p_end_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> !frame_end);

    // R9: the alignment flag only accompanies the end pulse.
    p_ok_with_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ok |-> frame_end);

    // R6: a byte takes at least two edges, so data strobes never touch.
    p_data_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |=> !data_valid);

    // R2: at most one strobe per cycle.
    p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({opcode_valid, addr_valid, data_valid, frame_end}));

endmodule

bind mlr_cmd_rx mlr_checker u_mlr_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_n         (cs_n),
    .opcode_valid (opcode_valid),
    .addr_valid   (addr_valid),
    .data_valid   (data_valid),
    .frame_end    (frame_end),
    .frame_ok     (frame_ok)
);

// File: tb/mlr_cmd_rx_bench.sv
`timescale 1ns/1ps
module mlr_cmd_rx_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic [3:0]  dq = 4'h0;
    logic [7:0]  opcode;
    logic        opcode_valid;
    logic [23:0] addr;
    logic        addr_valid;
    logic [7:0]  data_byte;
    logic        data_valid;
    logic        frame_end;
    logic        frame_ok;

    always #2.5 clk = ~clk;

    mlr_cmd_rx u_mlr_cmd_rx (
        .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .dq (dq),
        .opcode (opcode), .opcode_valid (opcode_valid),
        .addr (addr), .addr_valid (addr_valid),
        .data_byte (data_byte), .data_valid (data_valid),
        .frame_end (frame_end), .frame_ok (frame_ok)
    );

    int vec = 0;
    int bad = 0;
    bit done = 0;
    int cyc = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: samples strobes at the falling edge.
    logic [7:0]  mon_opc;
    logic [23:0] mon_addr;
    logic [7:0]  mon_data [64];
    int mon_opc_n, mon_addr_n, mon_data_n, mon_end_n;
    int mon_opc_cyc, mon_addr_cyc, mon_d0_cyc, mon_end_cyc;
    logic mon_ok;

    always @(negedge clk) begin
        if (opcode_valid) begin mon_opc = opcode; mon_opc_n++; mon_opc_cyc = cyc; end
        if (addr_valid) begin mon_addr = addr; mon_addr_n++; mon_addr_cyc = cyc; end
        if (data_valid) begin
            if (mon_data_n < 64) mon_data[mon_data_n] = data_byte;
            if (mon_data_n == 0) mon_d0_cyc = cyc;
            mon_data_n++;
        end
        if (frame_end) begin mon_ok = frame_ok; mon_end_n++; mon_end_cyc = cyc; end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        vec++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reference lane map (R3).
    function automatic bit is_known(input logic [7:0] o);
        return o == 8'h02 || o == 8'hA2 || o == 8'hD2 || o == 8'h32 || o == 8'h12;
    endfunction
    function automatic int addr_lanes(input logic [7:0] o);
        if (o == 8'hD2) return 2;
        if (o == 8'h12) return 4;
        if (is_known(o)) return 1;
        return 4;
    endfunction
    function automatic int data_lanes(input logic [7:0] o);
        if (o == 8'hA2 || o == 8'hD2) return 2;
        if (o == 8'h32 || o == 8'h12) return 4;
        if (o == 8'h02) return 1;
        return 4;
    endfunction
    // Group k of a value, MSB first (R4).
    function automatic logic [3:0] grp(input logic [23:0] v, input int nbits,
                                       input int w, input int k);
        logic [23:0] s;
        s = v >> (nbits - w * (k + 1));
        return s[3:0] & 4'((1 << w) - 1);
    endfunction

    task automatic unit(input logic [3:0] v);
        dq = v;
        @(negedge clk);
    endtask

    // cut < 0: full address. extra: leftover data units after the bytes.
    task automatic run_frame(input logic [7:0] opc, input logic [23:0] a,
                             input int nbytes, input int extra, input int cut);
        logic [7:0] exp_d [64];
        int al, dl, full, au, t0, units;
        bit kn, ok_exp;
        string dtag;
        kn = is_known(opc);
        al = addr_lanes(opc);
        dl = data_lanes(opc);
        full = 24 / al;
        au = (cut < 0) ? full : cut;
        mon_opc_n = 0; mon_addr_n = 0; mon_data_n = 0; mon_end_n = 0; mon_ok = 1'b0;
        t0 = cyc;
        cs_n = 1'b0;
        for (int i = 0; i < 8; i++) unit({3'b000, opc[7-i]});
        for (int k = 0; k < au; k++) unit(grp(a, 24, al, k));
        units = 8 + au;
        if (au == full) begin
            for (int b = 0; b < nbytes; b++) begin
                exp_d[b] = 8'($urandom);
                for (int k = 0; k < 8 / dl; k++) unit(grp({16'h0, exp_d[b]}, 8, dl, k));
                units += 8 / dl;
            end
            for (int e = 0; e < extra; e++) unit(4'($urandom));
            units += extra;
        end
        cs_n = 1'b1;
        dq = 4'h0;
        repeat (3) @(negedge clk);
        dtag = (dl > 1) ? "R4" : "R6";

        check(mon_opc_n == 1, "R2", "opcode strobe count", mon_opc_n, 1);
        check(mon_opc == opc, "R2", "opcode value", mon_opc, opc);
        check(mon_opc_cyc - t0 == 8, "R2", "opcode cycle", mon_opc_cyc - t0, 8);
        if (kn && au == full) begin
            check(mon_addr_n == 1, "R5", "addr strobe count", mon_addr_n, 1);
            check(mon_addr == a, "R5", "addr value", mon_addr, a);
            check(mon_addr_cyc - t0 == 8 + full, "R3", "addr cycle",
                  mon_addr_cyc - t0, 8 + full);
            check(mon_data_n == nbytes, "R6", "data count", mon_data_n, nbytes);
            for (int b = 0; b < nbytes && b < mon_data_n && b < 64; b++)
                check(mon_data[b] == exp_d[b], dtag, "data value", mon_data[b], exp_d[b]);
            if (nbytes > 0 && mon_data_n > 0)
                check(mon_d0_cyc - t0 == 8 + full + 8 / dl, "R3", "first data cycle",
                      mon_d0_cyc - t0, 8 + full + 8 / dl);
        end else begin
            check(mon_addr_n == 0, kn ? "R10" : "R7", "addr strobe count", mon_addr_n, 0);
            check(mon_data_n == 0, kn ? "R10" : "R7", "data count", mon_data_n, 0);
        end
        check(mon_end_n == 1, "R8", "frame_end count", mon_end_n, 1);
        check(mon_end_cyc - t0 == units + 1, "R8", "frame_end cycle",
              mon_end_cyc - t0, units + 1);
        ok_exp = kn && (au == full) && (nbytes > 0) && (extra == 0);
        check(mon_ok == ok_exp, "R9", "frame_ok", mon_ok, ok_exp);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] opcs [5];
        logic [7:0] o;
        int dl, nb, ex, ct;
        void'($urandom(32'h1F2E3D4C));
        opcs[0] = 8'h02; opcs[1] = 8'hA2; opcs[2] = 8'hD2; opcs[3] = 8'h32; opcs[4] = 8'h12;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!opcode_valid && !addr_valid && !data_valid && !frame_end && !frame_ok,
              "R1", "strobes in reset", {opcode_valid, addr_valid, data_valid, frame_end, frame_ok}, 0);
        check(opcode == 0 && addr == 0 && data_byte == 0, "R1", "words in reset",
              {opcode, addr, data_byte}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!frame_end && !opcode_valid, "R1", "idle after reset",
              {frame_end, opcode_valid}, 0);

        // Directed: every mode, fixed patterns (R3, R4, R5, R6)
        run_frame(8'h02, 24'hA5C3F0, 3, 0, -1);
        run_frame(8'hA2, 24'h123456, 2, 0, -1);
        run_frame(8'hD2, 24'hFEDCBA, 4, 0, -1);
        run_frame(8'h32, 24'h800001, 1, 0, -1);
        run_frame(8'h12, 24'h0F0F0F, 5, 0, -1);
        // R7: unknown opcode, next frame normal
        run_frame(8'h0B, 24'hFFFFFF, 3, 0, -1);
        run_frame(8'h12, 24'h13579B, 2, 0, -1);
        // R9: partial byte, zero bytes; R10: cut address
        run_frame(8'hA2, 24'h111111, 2, 3, -1);
        run_frame(8'h32, 24'h222222, 0, 0, -1);
        run_frame(8'h02, 24'h333333, 0, 0, 10);
        run_frame(8'h12, 24'h444444, 0, 0, 3);
        run_frame(8'h02, 24'h555555, 1, 7, -1);

        // Random frames
        for (int n = 0; n < 60; n++) begin
            if ($urandom_range(5) == 0) begin
                do o = 8'($urandom); while (is_known(o));
            end else begin
                o = opcs[$urandom_range(4)];
            end
            dl = data_lanes(o);
            nb = $urandom_range(6);
            ex = ($urandom_range(3) == 0) ? $urandom_range(8 / dl - 1) : 0;
            ct = ($urandom_range(7) == 0) ? $urandom_range(24 / addr_lanes(o) - 1) : -1;
            run_frame(o, 24'($urandom), nb, ex, ct);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

endmodule